// File: doc/BRIEF.md
# High-Speed Burst Tail Packet Inserter

This block sits in the transmit byte path of a multi-lane serial display link. It passes upstream byte beats through to the lane serializers. It also tracks whether the link is in a high-speed burst or in low-power mode. When the upstream burst-active signal falls and the tail feature is enabled, the block stops taking upstream beats. It then emits a fixed four-byte closing short packet, spread round-robin over the configured lanes. Only after the last of those bytes has been accepted does it let the link return to low-power mode. Nothing is appended when the feature is off, and nothing is ever appended to low-power traffic.

Both the transmit byte path and a separate receive path use valid/ready. A beat moves only in a cycle where valid and ready are both high. A producer that has raised valid must hold the beat unchanged until it is taken. Downstream may hold ready low for any number of cycles; the block then keeps its output beat stable. The receive path is a single register stage. It forwards every beat bit for bit, including closing packets from the far end, and does not interpret them.

Top module: `hs_tail_inserter`

## Requirements
- R1: After reset, `lp_req` is 1, `out_valid` is 0 and `rx_out_valid` is 0.
- R2: In low-power mode with `hs_active` low, `out_valid`, `out_data` and `out_lane_vld` follow the upstream beat in the same cycle, and `in_ready` equals `out_ready`.
- R3: In low-power mode, a cycle with `hs_active` high accepts no upstream beat (`in_ready` 0), and `lp_req` is 0 from the next cycle on.
- R4: In high-speed mode with `hs_active` high, upstream beats pass through unchanged in the same cycle, with `in_ready` equal to `out_ready`.
- R5: In high-speed mode, a cycle with `hs_active` low has `in_ready` 0. If `cfg_tail_en` is 1 in that cycle, the block then emits the closing packet. Its byte sequence is 0x08 (virtual channel 0 in bits 7:6, data type 0b001000 in bits 5:0), then 0x0F (payload bits 7:0), then 0x0F (payload bits 15:8), then 0x01 (check byte). Byte i goes to beat i / LANES, lane i mod LANES, where lane l occupies `out_data[8l+7:8l]`. `in_ready` stays 0 throughout.
- R6: In any closing-packet beat, a lane with no packet byte has its `out_lane_vld` bit at 0 and its data byte at 0x00. Lane 0 always carries a byte.
- R7: While a closing-packet beat is offered and `out_ready` is 0, the beat stays valid with unchanged data and lane mask.
- R8: `lp_req` stays 0 while the closing packet is pending. It becomes 1 in the cycle after the handshake of the last closing beat.
- R9: If `cfg_tail_en` is 0 when the burst ends, no packet is emitted, and `lp_req` is 1 in the very next cycle.
- R10: Traffic sent in low-power mode is never followed by an appended packet: once upstream goes idle, `out_valid` stays 0.
- R11: A receive beat accepted with `rx_in_valid` and `rx_in_ready` both high appears on `rx_out_data` in the next cycle, unchanged. It is held there while `rx_out_ready` is 0, and `rx_in_ready` is `!rx_out_valid || rx_out_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_tail_en | input | 1 | Enables the closing packet at burst end |
| hs_active | input | 1 | Upstream high-speed burst in progress |
| in_valid | input | 1 | Upstream beat valid |
| in_ready | output | 1 | Upstream beat accepted when high with in_valid |
| in_data | input | 8*LANES | Upstream bytes, lane l at bits 8l+7:8l |
| in_lane_vld | input | LANES | Upstream per-lane byte valid |
| out_valid | output | 1 | Lane beat valid |
| out_ready | input | 1 | Lane serializers accept the beat |
| out_data | output | 8*LANES | Lane bytes, lane l at bits 8l+7:8l |
| out_lane_vld | output | LANES | Per-lane byte valid |
| lp_req | output | 1 | Low-power request to the PHY (1 = low-power) |
| rx_in_valid | input | 1 | Receive beat valid from the PHY side |
| rx_in_ready | output | 1 | Receive beat accepted |
| rx_in_data | input | 8*LANES | Receive bytes |
| rx_out_valid | output | 1 | Forwarded receive beat valid |
| rx_out_ready | input | 1 | Receive consumer ready |
| rx_out_data | output | 8*LANES | Forwarded receive bytes |

## Verification
The bench uses three lanes, so the packet ends with a beat where only lane 0 is valid. A design that repeated bytes, or left stale data on the idle lanes, would show the wrong mask or nonzero bytes there. For each enable setting it sweeps burst lengths and back-pressure lengths on every closing beat. An early `lp_req`, a beat that changes under stall, or a packet emitted with the enable off shows up as a mismatch in the exact cycle. Low-power traffic is followed by idle cycles, which exposes any packet wrongly appended there. Received closing-packet bytes are pushed through the forwarding stage under stalls, to catch a design that decodes or drops them.

// File: rtl/hs_tail_pkg.sv
package hs_tail_pkg;
  typedef enum logic [1:0] {
    MODE_LP   = 2'd0,
    MODE_HS   = 2'd1,
    MODE_TAIL = 2'd2
  } link_mode_e;

  localparam int TAIL_BYTES = 4;

  // Closing packet content: identifier, payload low, payload high, check byte.
  function automatic logic [7:0] tail_byte(input int idx);
    case (idx)
      0:       tail_byte = 8'h08;
      1:       tail_byte = 8'h0F;
      2:       tail_byte = 8'h0F;
      3:       tail_byte = 8'h01;
      default: tail_byte = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/hs_tail_beat_rom.sv
module hs_tail_beat_rom #(
  parameter int LANES  = 4,
  parameter int BEAT_W = 1
) (
  input  logic [BEAT_W-1:0]  beat,
  output logic [8*LANES-1:0] data,
  output logic [LANES-1:0]   lane_vld
);
  import hs_tail_pkg::*;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_comb begin
      int idx;
      idx = int'(beat) * LANES + l;
      if (idx < TAIL_BYTES) begin
        data[8*l +: 8] = tail_byte(idx);
        lane_vld[l]    = 1'b1;
      end else begin
        data[8*l +: 8] = 8'h00;
        lane_vld[l]    = 1'b0;
      end
    end
  end
endmodule

// File: rtl/hs_tail_mode_fsm.sv
module hs_tail_mode_fsm #(
  parameter int NBEATS = 1,
  parameter int BEAT_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hs_active,
  input  logic              cfg_tail_en,
  input  logic              tail_fire,
  output logic              pass_ok,
  output logic              tail_busy,
  output logic [BEAT_W-1:0] tail_beat,
  output logic              lp_req
);
  import hs_tail_pkg::*;

  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(NBEATS - 1);

  link_mode_e mode_q, mode_d;
  logic [BEAT_W-1:0] beat_q, beat_d;

  always_comb begin
    mode_d = mode_q;
    beat_d = beat_q;
    case (mode_q)
      MODE_LP: if (hs_active) mode_d = MODE_HS;
      MODE_HS: if (!hs_active) begin
        mode_d = cfg_tail_en ? MODE_TAIL : MODE_LP;
        beat_d = '0;
      end
      MODE_TAIL: if (tail_fire) begin
        if (beat_q == LAST_BEAT) mode_d = MODE_LP;
        else                     beat_d = beat_q + 1'b1;
      end
      default: mode_d = MODE_LP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_LP;
      beat_q <= '0;
    end else begin
      mode_q <= mode_d;
      beat_q <= beat_d;
    end
  end

  assign pass_ok   = (mode_q == MODE_LP && !hs_active) || (mode_q == MODE_HS && hs_active);
  assign tail_busy = (mode_q == MODE_TAIL);
  assign tail_beat = beat_q;
  assign lp_req    = (mode_q == MODE_LP);
endmodule

// File: rtl/hs_tail_rx_stage.sv
module hs_tail_rx_stage #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         s_valid,
  output logic         s_ready,
  input  logic [W-1:0] s_data,
  output logic         m_valid,
  input  logic         m_ready,
  output logic [W-1:0] m_data
);
  logic         v_q;
  logic [W-1:0] d_q;

  assign s_ready = !v_q || m_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= 1'b0;
      d_q <= '0;
    end else if (s_valid && s_ready) begin
      v_q <= 1'b1;
      d_q <= s_data;
    end else if (m_ready) begin
      v_q <= 1'b0;
    end
  end

  assign m_valid = v_q;
  assign m_data  = d_q;
endmodule

// File: rtl/hs_tail_inserter.sv
module hs_tail_inserter #(
  parameter int LANES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_tail_en,
  input  logic               hs_active,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [8*LANES-1:0] in_data,
  input  logic [LANES-1:0]   in_lane_vld,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [8*LANES-1:0] out_data,
  output logic [LANES-1:0]   out_lane_vld,
  output logic               lp_req,
  input  logic               rx_in_valid,
  output logic               rx_in_ready,
  input  logic [8*LANES-1:0] rx_in_data,
  output logic               rx_out_valid,
  input  logic               rx_out_ready,
  output logic [8*LANES-1:0] rx_out_data
);
  import hs_tail_pkg::*;

  localparam int NBEATS = (TAIL_BYTES + LANES - 1) / LANES;
  localparam int BEAT_W = (NBEATS > 1) ? $clog2(NBEATS) : 1;

  logic               pass_ok;
  logic               tail_busy;
  logic [BEAT_W-1:0]  tail_beat;
  logic [8*LANES-1:0] rom_data;
  logic [LANES-1:0]   rom_vld;
  logic               tail_fire;

  assign tail_fire = tail_busy && out_ready;

  hs_tail_mode_fsm #(.NBEATS(NBEATS), .BEAT_W(BEAT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .hs_active(hs_active), .cfg_tail_en(cfg_tail_en),
    .tail_fire(tail_fire), .pass_ok(pass_ok), .tail_busy(tail_busy),
    .tail_beat(tail_beat), .lp_req(lp_req)
  );

  hs_tail_beat_rom #(.LANES(LANES), .BEAT_W(BEAT_W)) u_rom (
    .beat(tail_beat), .data(rom_data), .lane_vld(rom_vld)
  );

  always_comb begin
    if (tail_busy) begin
      out_valid    = 1'b1;
      out_data     = rom_data;
      out_lane_vld = rom_vld;
      in_ready     = 1'b0;
    end else begin
      out_valid    = pass_ok && in_valid;
      out_data     = in_data;
      out_lane_vld = in_lane_vld;
      in_ready     = pass_ok && out_ready;
    end
  end

  hs_tail_rx_stage #(.W(8*LANES)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .s_valid(rx_in_valid), .s_ready(rx_in_ready), .s_data(rx_in_data),
    .m_valid(rx_out_valid), .m_ready(rx_out_ready), .m_data(rx_out_data)
  );
endmodule

// File: rtl/hs_tail_inserter_chk.sv
module hs_tail_inserter_chk #(
  parameter int LANES = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_ready,
  input logic               out_valid,
  input logic               out_ready,
  input logic [8*LANES-1:0] out_data,
  input logic [LANES-1:0]   out_lane_vld,
  input logic               lp_req,
  input logic               tail_busy,
  input logic               rx_out_valid,
  input logic               rx_out_ready,
  input logic [8*LANES-1:0] rx_out_data
);
  p_tail_blocks_input_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tail_busy |-> !in_ready);

  p_tail_lane0_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tail_busy |-> (out_valid && out_lane_vld[0]));

  p_tail_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tail_busy && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_lane_vld)));

  p_no_lp_in_tail_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tail_busy |-> !lp_req);

  p_lp_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(lp_req) && $past(tail_busy)) |-> $past(out_ready));

  p_rx_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_out_valid && !rx_out_ready) |=> (rx_out_valid && $stable(rx_out_data)));
endmodule

bind hs_tail_inserter hs_tail_inserter_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_lane_vld(out_lane_vld),
  .lp_req(lp_req), .tail_busy(tail_busy), .rx_out_valid(rx_out_valid),
  .rx_out_ready(rx_out_ready), .rx_out_data(rx_out_data)
);

// File: tb/test_hs_tail_inserter.sv
module test_hs_tail_inserter;
  localparam int CLK_P  = 10;
  localparam int LANES  = 3;
  localparam int W      = 8 * LANES;
  localparam int NBEATS = (4 + LANES - 1) / LANES;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_tail_en = 1'b0, hs_active = 1'b0, in_valid = 1'b0, out_ready = 1'b1;
  logic [W-1:0] in_data = '0;
  logic [LANES-1:0] in_lane_vld = '0;
  logic in_ready, out_valid, lp_req;
  logic [W-1:0] out_data;
  logic [LANES-1:0] out_lane_vld;
  logic rx_in_valid = 1'b0, rx_out_ready = 1'b1;
  logic [W-1:0] rx_in_data = '0;
  logic rx_in_ready, rx_out_valid;
  logic [W-1:0] rx_out_data;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  hs_tail_inserter #(.LANES(LANES)) i_hs_tail_inserter (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] pkt_byte(input int i);
    logic [7:0] b [4] = '{8'h08, 8'h0F, 8'h0F, 8'h01};
    return (i < 4) ? b[i] : 8'h00;
  endfunction

  function automatic logic [W-1:0] exp_data(input int k);
    logic [W-1:0] d = '0;
    for (int l = 0; l < LANES; l++) d[8*l +: 8] = pkt_byte(k*LANES + l);
    return d;
  endfunction

  function automatic logic [LANES-1:0] exp_mask(input int k);
    logic [LANES-1:0] m = '0;
    for (int l = 0; l < LANES; l++) m[l] = (k*LANES + l) < 4;
    return m;
  endfunction

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_burst(input bit en, input int nburst, input int stall);
    cfg_tail_en = en; hs_active = 1'b1; in_valid = 1'b1; in_data = '1; out_ready = 1'b1;
    #1;
    chk("R3 no take on switch", {31'd0, in_ready}, 32'd0);
    chk("R3 lp before switch", {31'd0, lp_req}, 32'd1);
    in_valid = 1'b0;
    cyc();
    chk("R3 lp dropped", {31'd0, lp_req}, 32'd0);
    for (int b = 0; b < nburst; b++) begin
      in_valid = 1'b1; in_data = W'(32'h00A51C * (b + 1) + stall); in_lane_vld = LANES'(b + 1);
      #1;
      chk("R4 hs valid", {31'd0, out_valid}, 32'd1);
      chk("R4 hs data", 32'(out_data), 32'(in_data));
      chk("R4 hs mask", 32'(out_lane_vld), 32'(in_lane_vld));
      chk("R4 hs ready", {31'd0, in_ready}, 32'd1);
      cyc();
    end
    in_valid = 1'b1; in_data = '0; hs_active = 1'b0;
    #1;
    chk("R5 stop taking at end", {31'd0, in_ready}, 32'd0);
    cyc();
    if (!en) begin
      chk("R9 lp at once", {31'd0, lp_req}, 32'd1);
      in_valid = 1'b0;
      #1;
      chk("R9 no packet", {31'd0, out_valid}, 32'd0);
      return;
    end
    for (int k = 0; k < NBEATS; k++) begin
      for (int s = 0; s < stall; s++) begin
        out_ready = 1'b0;
        #1;
        chk("R8 lp held", {31'd0, lp_req}, 32'd0);
        cyc();
        chk("R7 held valid", {31'd0, out_valid}, 32'd1);
        chk("R7 held data", 32'(out_data), 32'(exp_data(k)));
      end
      out_ready = 1'b1;
      #1;
      chk("R5 tail valid", {31'd0, out_valid}, 32'd1);
      chk("R5 tail data", 32'(out_data), 32'(exp_data(k)));
      chk("R6 tail mask", 32'(out_lane_vld), 32'(exp_mask(k)));
      chk("R5 input blocked", {31'd0, in_ready}, 32'd0);
      chk("R8 lp low in tail", {31'd0, lp_req}, 32'd0);
      cyc();
    end
    chk("R8 lp after last", {31'd0, lp_req}, 32'd1);
    in_valid = 1'b0;
    #1;
    chk("R8 idle after tail", {31'd0, out_valid}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 lp_req", {31'd0, lp_req}, 32'd1);
    chk("R1 out_valid", {31'd0, out_valid}, 32'd0);
    chk("R1 rx_out_valid", {31'd0, rx_out_valid}, 32'd0);
    rst_n = 1'b1;
    cyc();
    for (int en = 0; en < 2; en++)
      for (int nb = 0; nb < 4; nb++)
        for (int st = 0; st < 3; st++)
          run_burst(en[0], nb, st);
    // R2 and R10: low-power traffic passes and nothing follows it
    cfg_tail_en = 1'b1;
    for (int b = 0; b < 4; b++) begin
      in_valid = 1'b1; in_data = W'(32'h3C00 + b); in_lane_vld = '1; out_ready = b[0];
      #1;
      chk("R2 lp data", 32'(out_data), 32'(in_data));
      chk("R2 lp valid", {31'd0, out_valid}, 32'd1);
      chk("R2 lp ready", {31'd0, in_ready}, {31'd0, out_ready});
      cyc();
    end
    in_valid = 1'b0; out_ready = 1'b1;
    for (int i = 0; i < 4; i++) begin
      #1;
      chk("R10 nothing appended", {31'd0, out_valid}, 32'd0);
      chk("R10 lp stays", {31'd0, lp_req}, 32'd1);
      cyc();
    end
    // R11: receive forwarding of closing-packet bytes with stalls
    for (int k = 0; k < 4; k++) begin
      rx_in_valid = 1'b1; rx_in_data = W'({pkt_byte(k), pkt_byte(3-k), pkt_byte(k)}); rx_out_ready = 1'b1;
      #1;
      chk("R11 rx ready", {31'd0, rx_in_ready}, 32'd1);
      cyc();
      rx_in_valid = 1'b0;
      chk("R11 rx valid", {31'd0, rx_out_valid}, 32'd1);
      chk("R11 rx data", 32'(rx_out_data), 32'(rx_in_data));
      rx_out_ready = 1'b0;
      cyc();
      #1;
      chk("R11 rx held", 32'(rx_out_data), 32'(rx_in_data));
      chk("R11 rx full blocks", {31'd0, rx_in_ready}, 32'd0);
      rx_out_ready = 1'b1;
      cyc();
      chk("R11 rx drained", {31'd0, rx_out_valid}, 32'd0);
    end
    finished = 1;
  end

  initial begin
    for (int i = 0; i < 20000 && !finished; i++) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule